// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block sits next to a floating-point adder or multiplier. It looks at the two IEEE-754 operands of an operation and decides whether the result must be a NaN. When at least one operand is a NaN, the block raises an override flag and supplies the NaN to return, so the arithmetic result can be replaced. It also raises an invalid-operation flag whenever a signaling NaN is present. A parameter selects single or double precision. The selection logic is purely combinational.

There are two propagation rules. In magnitude mode, a quiet NaN wins over a signaling one. Between NaNs of the same kind, the one with the larger fraction wins, and a tie goes to the NaN with a clear sign bit. In first-operand mode, the first operand that is a NaN is returned. A configuration register captures the rule-select input once, at the first rising clock edge after reset is released. It keeps that value until the next reset.

Top module: `nan_sel_top`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. An all-ones exponent with a zero fraction (infinity) is not a NaN. `nan_override_o` is 1 exactly when at least one operand is a NaN.
- R2: `invalid_o` is 1 exactly when at least one operand is a signaling NaN (fraction MSB 0), under either rule.
- R3: When exactly one operand is a quiet NaN (fraction MSB 1) and the other is not a NaN, the result is that operand unchanged.
- R4: When exactly one operand is a signaling NaN and the other is not a NaN, the result is that operand with the fraction MSB set. Sign and all other bits are unchanged.
- R5: In magnitude mode, when one operand is a quiet NaN and the other is a signaling NaN, the result is the quiet one.
- R6: In magnitude mode, when both NaNs are of the same kind, the result is the one whose fraction field is larger as an unsigned number, quieted.
- R7: In magnitude mode, when both NaNs are of the same kind and have equal fractions, the result is the one with sign bit 0, if either has one.
- R8: In first-operand mode, when both operands are NaNs, the result is operand A, quieted, whatever its kind or fraction.
- R9: The rule is captured from `rule_sel_i` at the first rising edge after reset release (0 = magnitude, 1 = first-operand). Later changes of `rule_sel_i` have no effect until the next reset.
- R10: When neither operand is a NaN, `nan_override_o` and `invalid_o` are 0 and `nan_result_o` is all zeros. This also holds during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| rule_sel_i | input | 1 | Rule request: 0 magnitude, 1 first-operand |
| opa_i | input | W (32 or 64) | First operand |
| opb_i | input | W (32 or 64) | Second operand |
| nan_override_o | output | 1 | A NaN result replaces the arithmetic result |
| nan_result_o | output | W (32 or 64) | Propagated NaN, zero when no override |
| invalid_o | output | 1 | A signaling NaN operand is present |

## Verification
The only state in the block is the captured rule. If that register holds the wrong value, or changes after capture, it shows up at the ports on the next cycle. Any pair of NaNs then goes through the other rule: the output takes the wrong operand, or the quiet one loses to a larger signaling one. For this reason every cycle presents an operand pair and compares it with a reference model, including pairs with equal fractions and mixed kinds. A fault in classification or quieting appears in the same cycle as a wrong flag or a result whose fraction MSB is clear.

// File: rtl/nan_sel_pkg.sv
package nan_sel_pkg;
  typedef enum logic {
    RULE_MAGNITUDE = 1'b0,
    RULE_FIRST     = 1'b1
  } nan_rule_e;
endpackage

// File: rtl/nan_rule_reg.sv
module nan_rule_reg
  import nan_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_i,
  output nan_rule_e rule_o
);
  nan_rule_e rule_q, rule_d;
  logic      armed_q, armed_d;
  logic      cap_en;

  assign cap_en = ~armed_q;

  always_comb begin
    rule_d  = rule_q;
    armed_d = armed_q;
    if (cap_en) begin
      rule_d  = nan_rule_e'(sel_i);
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rule_q  <= RULE_MAGNITUDE;
      armed_q <= 1'b0;
    end else if (cap_en) begin
      rule_q  <= rule_d;
      armed_q <= armed_d;
    end
  end

  assign rule_o = rule_q;
endmodule

// File: rtl/nan_classify.sv
module nan_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]      op_i,
  output logic              is_nan_o,
  output logic              is_snan_o,
  output logic              sign_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [W-1:0]      quiet_o
);
  logic [EXP_W-1:0] exp_f;

  assign sign_o    = op_i[W-1];
  assign exp_f     = op_i[W-2:FRAC_W];
  assign frac_o    = op_i[FRAC_W-1:0];
  assign is_nan_o  = (&exp_f) && (|frac_o);
  assign is_snan_o = is_nan_o && !frac_o[FRAC_W-1];
  assign quiet_o   = {op_i[W-1:FRAC_W], 1'b1, op_i[FRAC_W-2:0]};
endmodule

// File: rtl/nan_pick.sv
module nan_pick
  import nan_sel_pkg::*;
#(
  parameter int FRAC_W = 23,
  parameter int W      = 32
) (
  input  nan_rule_e         rule_i,
  input  logic              a_nan_i,
  input  logic              a_snan_i,
  input  logic              a_sign_i,
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic [W-1:0]      a_quiet_i,
  input  logic              b_nan_i,
  input  logic              b_snan_i,
  input  logic              b_sign_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  input  logic [W-1:0]      b_quiet_i,
  output logic              override_o,
  output logic              invalid_o,
  output logic [W-1:0]      result_o
);
  logic take_b;

  always_comb begin
    take_b = 1'b0;
    if (a_nan_i && b_nan_i) begin
      if (rule_i == RULE_FIRST) begin
        take_b = 1'b0;
      end else if (a_snan_i != b_snan_i) begin
        take_b = a_snan_i;
      end else if (a_frac_i != b_frac_i) begin
        take_b = (b_frac_i > a_frac_i);
      end else begin
        take_b = a_sign_i && !b_sign_i;
      end
    end else begin
      take_b = b_nan_i;
    end
  end

  assign override_o = a_nan_i || b_nan_i;
  assign invalid_o  = a_snan_i || b_snan_i;
  assign result_o   = !override_o ? '0 : (take_b ? b_quiet_i : a_quiet_i);
endmodule

// File: rtl/nan_sel_top.sv
module nan_sel_top
  import nan_sel_pkg::*;
#(
  parameter bit  DOUBLE_PREC = 1'b0,
  localparam int EXP_W  = DOUBLE_PREC ? 11 : 8,
  localparam int FRAC_W = DOUBLE_PREC ? 52 : 23,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rule_sel_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         nan_override_o,
  output logic [W-1:0] nan_result_o,
  output logic         invalid_o
);
  nan_rule_e         rule;
  logic [1:0]        is_nan, is_snan, sign;
  logic [FRAC_W-1:0] frac [2];
  logic [W-1:0]      quiet [2];
  logic [W-1:0]      ops [2];

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;

  nan_rule_reg u_rule (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (rule_sel_i),
    .rule_o (rule)
  );

  for (genvar g = 0; g < 2; g++) begin : g_cls
    nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i      (ops[g]),
      .is_nan_o  (is_nan[g]),
      .is_snan_o (is_snan[g]),
      .sign_o    (sign[g]),
      .frac_o    (frac[g]),
      .quiet_o   (quiet[g])
    );
  end

  nan_pick #(.FRAC_W(FRAC_W), .W(W)) u_pick (
    .rule_i     (rule),
    .a_nan_i    (is_nan[0]),
    .a_snan_i   (is_snan[0]),
    .a_sign_i   (sign[0]),
    .a_frac_i   (frac[0]),
    .a_quiet_i  (quiet[0]),
    .b_nan_i    (is_nan[1]),
    .b_snan_i   (is_snan[1]),
    .b_sign_i   (sign[1]),
    .b_frac_i   (frac[1]),
    .b_quiet_i  (quiet[1]),
    .override_o (nan_override_o),
    .invalid_o  (invalid_o),
    .result_o   (nan_result_o)
  );
endmodule

// File: rtl/nan_sel_chk.sv
module nan_sel_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rule_bit,
  input logic         armed,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         nan_override_o,
  input logic [W-1:0] nan_result_o,
  input logic         invalid_o
);
  logic [W-1:0] qmask;
  assign qmask = W'(1) << (FRAC_W - 1);

  AST_INVALID_NEEDS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> nan_override_o); // R2

  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    nan_override_o |-> ((&nan_result_o[W-2:FRAC_W]) && nan_result_o[FRAC_W-1])); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !nan_override_o |-> (nan_result_o == '0 && !invalid_o)); // R10

  AST_FROM_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    nan_override_o |-> (nan_result_o == (opa_i | qmask) || nan_result_o == (opb_i | qmask))); // R6

  AST_RULE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> $stable(rule_bit)); // R9
endmodule

bind nan_sel_top nan_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rule_bit       (u_rule.rule_q),
  .armed          (u_rule.armed_q),
  .opa_i          (opa_i),
  .opb_i          (opb_i),
  .nan_override_o (nan_override_o),
  .nan_result_o   (nan_result_o),
  .invalid_o      (invalid_o)
);

// File: tb/nan_sel_top_tb_top.sv
module nan_sel_top_tb_top;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int W      = 1 + EXP_W + FRAC_W;

  logic         clk;
  logic         rst_n;
  logic         rule_sel_i;
  logic [W-1:0] opa_i, opb_i;
  logic         nan_override_o, invalid_o;
  logic [W-1:0] nan_result_o;

  int checks = 0;
  int fails  = 0;
  int model_rule = 0;

  nan_sel_top #(.DOUBLE_PREC(1'b0)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rule_sel_i     (rule_sel_i),
    .opa_i          (opa_i),
    .opb_i          (opb_i),
    .nan_override_o (nan_override_o),
    .nan_result_o   (nan_result_o),
    .invalid_o      (invalid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit is_nan(logic [W-1:0] x);
    return (x[W-2:FRAC_W] == '1) && (x[FRAC_W-1:0] != 0);
  endfunction
  function automatic bit is_sig(logic [W-1:0] x);
    return is_nan(x) && !x[FRAC_W-1];
  endfunction
  function automatic logic [W-1:0] quieten(logic [W-1:0] x);
    return x | (W'(1) << (FRAC_W - 1));
  endfunction

  function automatic logic [W-1:0] ref_result(logic [W-1:0] a, logic [W-1:0] b, int rule);
    if (!is_nan(a) && !is_nan(b)) return '0;
    if (!is_nan(b)) return quieten(a);
    if (!is_nan(a)) return quieten(b);
    if (rule == 1) return quieten(a);
    if (is_sig(a) && !is_sig(b)) return quieten(b);
    if (!is_sig(a) && is_sig(b)) return quieten(a);
    if (a[FRAC_W-1:0] > b[FRAC_W-1:0]) return quieten(a);
    if (b[FRAC_W-1:0] > a[FRAC_W-1:0]) return quieten(b);
    if (a[W-1] && !b[W-1]) return quieten(b);
    return quieten(a);
  endfunction

  function automatic string tag_of(logic [W-1:0] a, logic [W-1:0] b, int rule);
    if (!is_nan(a) && !is_nan(b))
      return ((a[W-2:FRAC_W] == '1) || (b[W-2:FRAC_W] == '1)) ? "R1" : "R10";
    if (!is_nan(a) || !is_nan(b)) return (is_sig(a) || is_sig(b)) ? "R4" : "R3";
    if (rule == 1) return "R8";
    if (is_sig(a) != is_sig(b)) return "R5";
    if (a[FRAC_W-1:0] == b[FRAC_W-1:0]) return "R7";
    return "R6";
  endfunction

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, string tag_over);
    logic [W-1:0] er;
    bit eo, ei;
    string tg;
    @(negedge clk);
    opa_i = a;
    opb_i = b;
    #2;
    er = ref_result(a, b, model_rule);
    eo = is_nan(a) || is_nan(b);
    ei = is_sig(a) || is_sig(b);
    tg = (tag_over != "") ? tag_over : tag_of(a, b, model_rule);
    checks++;
    if (nan_result_o !== er || nan_override_o !== eo || invalid_o !== ei) begin
      fails++;
      $display("FAIL %s (R1/R2 flags) a=%h b=%h: result=%h ovr=%b inv=%b expected result=%h ovr=%b inv=%b",
               tg, a, b, nan_result_o, nan_override_o, invalid_o, er, eo, ei);
    end
  endtask

  function automatic logic [W-1:0] mk(int kind, bit s, logic [FRAC_W-1:0] f);
    logic [W-1:0] x;
    case (kind)
      0: x = {s, 8'h40, f};
      1: x = {s, 8'hFF, 1'b1, f[FRAC_W-2:0]};
      2: x = {s, 8'hFF, 1'b0, (f[FRAC_W-2:0] == 0) ? 22'h1 : f[FRAC_W-2:0]};
      default: x = {s, 8'hFF, 23'h0};
    endcase
    return x;
  endfunction

  task automatic run_random(int n);
    for (int i = 0; i < n; i++) begin
      logic [FRAC_W-1:0] fa, fb;
      int ka, kb;
      ka = $urandom_range(0, 3);
      kb = $urandom_range(0, 3);
      fa = FRAC_W'($urandom);
      fb = ($urandom_range(0, 3) == 0) ? fa : FRAC_W'($urandom);
      apply(mk(ka, 1'($urandom), fa), mk(kb, 1'($urandom), fb), "");
    end
  endtask

  task automatic do_reset(bit rule);
    @(negedge clk);
    rst_n = 1'b0;
    rule_sel_i = rule;
    opa_i = 32'h3F80_0000;
    opb_i = 32'h4000_0000;
    #2;
    checks++;
    if (nan_override_o !== 1'b0 || invalid_o !== 1'b0 || nan_result_o !== '0) begin
      fails++;
      $display("FAIL R10 reset: ovr=%b inv=%b result=%h expected 0 0 0",
               nan_override_o, invalid_o, nan_result_o);
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    model_rule = rule;
  endtask

  task automatic directed();
    apply(32'h7F80_0000, 32'h3F80_0000, "R1");
    apply(32'h7F80_0001, 32'h3F80_0000, "R4");
    apply(32'h3F80_0000, 32'hFFC0_1234, "R3");
    apply(32'h7F80_0005, 32'h7FC0_0001, "");
    apply(32'h7FC0_0002, 32'h7F80_7777, "");
    apply(32'h7F80_0010, 32'hFF80_0020, "");
    apply(32'h7FC0_0030, 32'h7FC0_0031, "");
    apply(32'hFFC0_0044, 32'h7FC0_0044, "");
    apply(32'h7F80_0044, 32'hFF80_0044, "");
    apply(32'hFFC0_0044, 32'hFFC0_0044, "");
    apply(32'h7FFF_FFFF, 32'hFF80_0001, "");
  endtask

  initial begin
    rst_n = 1'b0;
    rule_sel_i = 1'b0;
    opa_i = '0;
    opb_i = '0;
    do_reset(1'b0);
    directed();
    run_random(300);
    rule_sel_i = 1'b1;   // R9: must be ignored
    apply(32'h7F80_0001, 32'h7FC0_0001, "R9");
    apply(32'h7FC0_0001, 32'h7FC0_0100, "R9");
    run_random(100);
    do_reset(1'b1);
    directed();
    run_random(300);
    rule_sel_i = 1'b0;   // R9: must be ignored
    apply(32'h7F80_0001, 32'h7FC0_0001, "R9");
    apply(32'h7FC0_0001, 32'h7FC0_0100, "R9");
    run_random(100);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule